// File: doc/BRIEF.md
# Floating-Point Significand Rounding Unit

This block sits at the tail of an add, subtract or divide datapath for single-precision values. It receives a sign, a biased exponent and a 24-bit significand with its hidden bit, together with three extra low-order bits called guard, round and sticky, in that order below the kept fraction. It first applies one requested shift. A right shift by a count aligns the value and raises the exponent. A one-place left shift normalizes the value and lowers the exponent. It then rounds the kept fraction under one of four selectable modes.

The result is registered once. The outputs are the rounded significand, the adjusted exponent and an inexact flag, and they appear one cycle after the request. If the increment overflows the significand, the significand is renormalized and the exponent is raised by one. Denormals, special values and exception traps are not handled here.

Top module: `fp_round_unit`

## Requirements
- R1: Shift code 01 shifts the 27-bit value {significand, guard, round, sticky} right by shift_amt_i places and adds shift_amt_i to the exponent. Codes 00 and 11 apply no shift.
- R2: On a right shift, the new sticky bit is the OR of the old sticky bit and every bit shifted through or out of the sticky position. A count of 27 or more leaves zeros above the sticky bit, and the sticky bit holds the OR of the whole input.
- R3: Shift code 10 shifts left one place, with the exponent reduced by one. The guard bit enters the significand LSB, round moves to guard, sticky moves to round, and sticky becomes 0.
- R4: Mode 00 (nearest even) increments when guard is 1 and at least one of round, sticky or the kept LSB is 1. On an exact tie (guard, round, sticky = 100), the result LSB is therefore 0.
- R5: Mode 01 (toward zero) never increments; guard, round and sticky are discarded.
- R6: Mode 10 (toward +infinity) increments a positive value (sign 0) when any of guard, round or sticky is 1. It never increments a negative value.
- R7: Mode 11 (toward -infinity) increments a negative value (sign 1) when any of guard, round or sticky is 1. It never increments a positive value.
- R8: If the increment carries out of the 24-bit significand, the result significand is 0x800000 and the exponent is raised by one more.
- R9: inexact_o is 1 exactly when guard, round or sticky is nonzero after the shift and before rounding.
- R10: valid_o is 1 exactly one cycle after valid_i was 1, and the data outputs change only with it. Reset clears valid_o, sig_o, exp_o and inexact_o to 0.
- R11: All exponent arithmetic wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| exp_i | input | 8 | Biased exponent |
| sig_i | input | 24 | Significand including hidden bit |
| grs_i | input | 3 | Guard (bit 2), round (bit 1), sticky (bit 0) |
| shift_op_i | input | 2 | 00 none, 01 right by count, 10 left one, 11 none |
| shift_amt_i | input | 5 | Right-shift count |
| mode_i | input | 2 | 00 nearest even, 01 toward zero, 10 toward +inf, 11 toward -inf |
| valid_o | output | 1 | Result strobe |
| sig_o | output | 24 | Rounded significand |
| exp_o | output | 8 | Adjusted exponent |
| inexact_o | output | 1 | Precision was lost |

## Verification
The assertions check relations on every cycle out of reset. They therefore assume that every input holds a known value from the first clock, including mode, sign and shift fields on cycles where valid_i is low. The bench drives all inputs to defined values from time zero and changes them only on the falling edge.

The exponent may wrap, so no assertion depends on the exponent's range. Random stimulus draws the full 24-bit significand, all guard, round and sticky patterns, and right-shift counts beyond the 27-bit width, with every shift code and mode.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_TO_ZERO   = 2'b01,
    RND_UP        = 2'b10,
    RND_DOWN      = 2'b11
  } rnd_mode_e;

  typedef enum logic [1:0] {
    SHF_NONE  = 2'b00,
    SHF_RIGHT = 2'b01,
    SHF_LEFT1 = 2'b10,
    SHF_RSVD  = 2'b11
  } shf_op_e;

  localparam int unsigned XTRA_W = 3;  // guard, round, sticky
endpackage

// File: rtl/fpr_shift.sv
module fpr_shift
  import fpr_pkg::*;
#(
  parameter int unsigned SIG_W = 24,
  parameter int unsigned EXP_W = 8,
  parameter int unsigned AMT_W = 5,
  localparam int unsigned EXT_W = SIG_W + XTRA_W
) (
  input  shf_op_e          op_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic [EXP_W-1:0] exp_o,
  output logic [EXT_W-1:0] ext_o
);
  logic [EXT_W-1:0] rs_shifted;
  logic             rs_sticky;

  // sticky collects every bit at or below the shift count
  always_comb begin
    rs_shifted = ext_i >> amt_i;
    rs_sticky  = 1'b0;
    for (int i = 0; i < EXT_W; i++) begin
      if (32'(i) <= 32'(amt_i)) rs_sticky = rs_sticky | ext_i[i];
    end
  end

  always_comb begin
    unique case (op_i)
      SHF_RIGHT: begin
        ext_o = {rs_shifted[EXT_W-1:1], rs_sticky};
        exp_o = exp_i + EXP_W'(amt_i);
      end
      SHF_LEFT1: begin
        ext_o = {ext_i[EXT_W-2:0], 1'b0};
        exp_o = exp_i - EXP_W'(1);
      end
      default: begin
        ext_o = ext_i;
        exp_o = exp_i;
      end
    endcase
  end
endmodule

// File: rtl/fpr_round.sv
module fpr_round
  import fpr_pkg::*;
#(
  parameter int unsigned SIG_W = 24,
  parameter int unsigned EXP_W = 8,
  localparam int unsigned EXT_W = SIG_W + XTRA_W
) (
  input  rnd_mode_e        mode_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [EXT_W-1:0] ext_i,
  output logic [SIG_W-1:0] sig_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             inexact_o,
  output logic             inc_o,
  output logic             carry_o
);
  logic [SIG_W-1:0] kept;
  logic             g_bit, r_bit, s_bit, lost;
  logic [SIG_W:0]   sum;

  assign kept  = ext_i[EXT_W-1:XTRA_W];
  assign g_bit = ext_i[2];
  assign r_bit = ext_i[1];
  assign s_bit = ext_i[0];
  assign lost  = g_bit | r_bit | s_bit;

  always_comb begin
    unique case (mode_i)
      RND_NEAR_EVEN: inc_o = g_bit & (r_bit | s_bit | kept[0]);
      RND_TO_ZERO:   inc_o = 1'b0;
      RND_UP:        inc_o = lost & ~sign_i;
      RND_DOWN:      inc_o = lost & sign_i;
      default:       inc_o = 1'b0;
    endcase
  end

  assign sum       = {1'b0, kept} + (SIG_W+1)'(inc_o);
  assign carry_o   = sum[SIG_W];
  assign sig_o     = carry_o ? sum[SIG_W:1] : sum[SIG_W-1:0];
  assign exp_o     = exp_i + EXP_W'(carry_o);
  assign inexact_o = lost;
endmodule

// File: rtl/fp_round_unit.sv
module fp_round_unit
  import fpr_pkg::*;
#(
  parameter int unsigned SIG_W = 24,
  parameter int unsigned EXP_W = 8,
  parameter int unsigned AMT_W = 5,
  localparam int unsigned EXT_W = SIG_W + XTRA_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             sign_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [SIG_W-1:0] sig_i,
  input  logic [2:0]       grs_i,
  input  logic [1:0]       shift_op_i,
  input  logic [AMT_W-1:0] shift_amt_i,
  input  logic [1:0]       mode_i,
  output logic             valid_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             inexact_o
);
  logic [EXT_W-1:0] shf_ext;
  logic [EXP_W-1:0] shf_exp;
  logic [SIG_W-1:0] rnd_sig;
  logic [EXP_W-1:0] rnd_exp;
  logic             rnd_inexact, rnd_inc, rnd_carry;

  fpr_shift #(.SIG_W(SIG_W), .EXP_W(EXP_W), .AMT_W(AMT_W)) i_shift (
    .op_i  (shf_op_e'(shift_op_i)),
    .amt_i (shift_amt_i),
    .exp_i (exp_i),
    .ext_i ({sig_i, grs_i}),
    .exp_o (shf_exp),
    .ext_o (shf_ext)
  );

  fpr_round #(.SIG_W(SIG_W), .EXP_W(EXP_W)) i_round (
    .mode_i    (rnd_mode_e'(mode_i)),
    .sign_i    (sign_i),
    .exp_i     (shf_exp),
    .ext_i     (shf_ext),
    .sig_o     (rnd_sig),
    .exp_o     (rnd_exp),
    .inexact_o (rnd_inexact),
    .inc_o     (rnd_inc),
    .carry_o   (rnd_carry)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      sig_o     <= '0;
      exp_o     <= '0;
      inexact_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        sig_o     <= rnd_sig;
        exp_o     <= rnd_exp;
        inexact_o <= rnd_inexact;
      end
    end
  end

  assert_valid_lat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(sig_o) && $stable(exp_o)));
  assert_sticky_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_op_i == SHF_RIGHT && grs_i[0]) |-> shf_ext[0]);
  assert_left_guard_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_op_i == SHF_LEFT1) |-> (shf_ext[XTRA_W] == grs_i[2] && !shf_ext[0]));
  assert_tie_even_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RND_NEAR_EVEN && shf_ext[2:0] == 3'b100) |-> !rnd_sig[0]);
  assert_trunc_no_inc_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RND_TO_ZERO) |-> !rnd_inc);
  assert_up_no_neg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RND_UP && sign_i) |-> !rnd_inc);
  assert_down_no_pos_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == RND_DOWN && !sign_i) |-> !rnd_inc);
  assert_carry_norm_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_carry |-> (rnd_sig == {1'b1, {(SIG_W-1){1'b0}}} && rnd_exp == shf_exp + EXP_W'(1)));
  assert_exact_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shf_ext[2:0] == 3'b000) |-> (!rnd_inc && !rnd_inexact));
endmodule

// File: tb/test_fp_round_unit.sv
module test_fp_round_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        sign_i = 1'b0;
  logic [7:0]  exp_i = '0;
  logic [23:0] sig_i = '0;
  logic [2:0]  grs_i = '0;
  logic [1:0]  shift_op_i = '0;
  logic [4:0]  shift_amt_i = '0;
  logic [1:0]  mode_i = '0;
  logic        valid_o;
  logic [23:0] sig_o;
  logic [7:0]  exp_o;
  logic        inexact_o;

  fp_round_unit i_fp_round_unit (.*);

  always #5 clk_i = ~clk_i;

  typedef struct {
    logic [23:0] sig;
    logic [7:0]  exp;
    logic        inexact;
    string       tag;
  } exp_t;

  exp_t q[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  function automatic exp_t model(logic s, logic [7:0] e, logic [23:0] m, logic [2:0] grs,
                                 logic [1:0] op, logic [4:0] n, logic [1:0] md, string tag);
    exp_t r;
    longint x = (longint'(m) << 3) | longint'(grs);
    longint mask27 = (64'd1 << 27) - 1;
    int ex = int'(e);
    longint k;
    bit g, rb, sb, any, inc;
    if (op == 2'b01) begin
      longint nx = x >> n;
      bit st = ((x & ((64'd1 << (int'(n) + 1)) - 1)) != 0);
      x = (nx & ~64'd1) | longint'(st);
      ex = ex + int'(n);
    end else if (op == 2'b10) begin
      x = (x << 1) & mask27;
      ex = ex - 1;
    end
    g = x[2]; rb = x[1]; sb = x[0];
    any = g | rb | sb;
    k = x >> 3;
    case (md)
      2'b00: inc = g && (rb || sb || k[0]);
      2'b01: inc = 0;
      2'b10: inc = any && !s;
      default: inc = any && s;
    endcase
    k = k + longint'(inc);
    if (k >= (64'd1 << 24)) begin
      k = k >> 1;
      ex = ex + 1;
    end
    r.sig = k[23:0];
    r.exp = 8'(ex & 255);
    r.inexact = any;
    r.tag = tag;
    return r;
  endfunction

  task automatic check_out();
    compared++;
    if (q.size() != 0) begin
      exp_t e = q.pop_front();
      if (valid_o !== 1'b1 || sig_o !== e.sig || exp_o !== e.exp || inexact_o !== e.inexact) begin
        mismatched++;
        $display("FAIL %s: got v=%b sig=%h exp=%h inx=%b, expected v=1 sig=%h exp=%h inx=%b",
                 e.tag, valid_o, sig_o, exp_o, inexact_o, e.sig, e.exp, e.inexact);
      end
    end else if (valid_o !== 1'b0) begin
      mismatched++;
      $display("FAIL R10: got valid_o=%b, expected 0", valid_o);
    end
  endtask

  task automatic step(bit v, logic s, logic [7:0] e, logic [23:0] m, logic [2:0] grs,
                      logic [1:0] op, logic [4:0] n, logic [1:0] md, string tag);
    @(negedge clk_i);
    check_out();
    valid_i = v; sign_i = s; exp_i = e; sig_i = m; grs_i = grs;
    shift_op_i = op; shift_amt_i = n; mode_i = md;
    if (v) q.push_back(model(s, e, m, grs, op, n, md, tag));
  endtask

  task automatic idle();
    step(0, 0, 8'h00, 24'h0, 3'b000, 2'b00, 5'd0, 2'b00, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    compared++;  // reset state, R10
    if (valid_o !== 0 || sig_o !== 0 || exp_o !== 0 || inexact_o !== 0) begin
      mismatched++;
      $display("FAIL R10: reset got v=%b sig=%h exp=%h inx=%b, expected all 0",
               valid_o, sig_o, exp_o, inexact_o);
    end
    rst_ni = 1'b1;
    idle();
    step(1, 0, 8'h40, 24'h800000, 3'b000, 2'b01, 5'd4, 2'b01, "R1");
    step(1, 0, 8'h40, 24'h9ABCDE, 3'b011, 2'b00, 5'd9, 2'b01, "R1");
    step(1, 0, 8'h40, 24'h9ABCDE, 3'b011, 2'b11, 5'd9, 2'b01, "R1");
    step(1, 0, 8'h20, 24'h80001F, 3'b000, 2'b01, 5'd5, 2'b01, "R2");
    step(1, 0, 8'h20, 24'h800000, 3'b001, 2'b01, 5'd2, 2'b01, "R2");
    step(1, 0, 8'h20, 24'h800001, 3'b000, 2'b01, 5'd30, 2'b01, "R2");
    step(1, 0, 8'h20, 24'h000000, 3'b001, 2'b01, 5'd27, 2'b10, "R2");
    step(1, 0, 8'h30, 24'h400001, 3'b101, 2'b10, 5'd0, 2'b01, "R3");
    step(1, 0, 8'h30, 24'h400000, 3'b011, 2'b10, 5'd0, 2'b00, "R3");
    step(1, 0, 8'h50, 24'hC00001, 3'b100, 2'b00, 5'd0, 2'b00, "R4");
    step(1, 0, 8'h50, 24'hC00002, 3'b100, 2'b00, 5'd0, 2'b00, "R4");
    step(1, 0, 8'h50, 24'hC00002, 3'b101, 2'b00, 5'd0, 2'b00, "R4");
    step(1, 0, 8'h50, 24'hC00003, 3'b011, 2'b00, 5'd0, 2'b00, "R4");
    step(1, 1, 8'h50, 24'hC00003, 3'b111, 2'b00, 5'd0, 2'b01, "R5");
    step(1, 0, 8'h50, 24'hC00003, 3'b001, 2'b00, 5'd0, 2'b10, "R6");
    step(1, 1, 8'h50, 24'hC00003, 3'b111, 2'b00, 5'd0, 2'b10, "R6");
    step(1, 1, 8'h50, 24'hC00003, 3'b010, 2'b00, 5'd0, 2'b11, "R7");
    step(1, 0, 8'h50, 24'hC00003, 3'b111, 2'b00, 5'd0, 2'b11, "R7");
    step(1, 0, 8'h0A, 24'hFFFFFF, 3'b100, 2'b00, 5'd0, 2'b00, "R8");
    step(1, 1, 8'h0A, 24'hFFFFFF, 3'b001, 2'b00, 5'd0, 2'b11, "R8");
    step(1, 0, 8'h0A, 24'hABCDEF, 3'b000, 2'b00, 5'd0, 2'b10, "R9");
    step(1, 0, 8'h0A, 24'hABCDE8, 3'b000, 2'b01, 5'd3, 2'b00, "R9");
    idle();
    idle();
    step(1, 0, 8'hFF, 24'h800000, 3'b000, 2'b01, 5'd2, 2'b00, "R11");
    step(1, 0, 8'h00, 24'h400000, 3'b000, 2'b10, 5'd0, 2'b00, "R11");
    step(1, 0, 8'hFF, 24'hFFFFFF, 3'b110, 2'b00, 5'd0, 2'b10, "R11");
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 4) != 0, 1'($urandom), 8'($urandom), 24'($urandom), 3'($urandom),
           2'($urandom), 5'($urandom), 2'($urandom), "R4");
    end
    idle();
    idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      mismatched++;
      $display("FAIL R10: watchdog expired, got hang, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule